// File: doc/BRIEF.md
# Maze-Foraging Robot Controller

This block is the decision core of a small robot that wanders a grid maze. It collects loose items one at a time and ejects them through openings in the ceiling. On every clock it looks at four wall sensors, four one-hot light-direction sensors, a low-battery flag, an item-present flag and an under-opening flag. It then commands at most one action: step forward, step backward, turn clockwise, turn anticlockwise, pick up, throw up, or exit. The controller remembers whether it is carrying an item. After the low-battery flag is first seen, it also keeps a budget of moves.

The block is built as a Moore machine. A decision taken in the search state shows up as a single-cycle command pulse in the next cycle. Multi-move manoeuvres (a turn followed by a step, or two clockwise turns to reverse) then run to completion before the next decision. The exit state is terminal. If the move budget runs out before an opening is reached, the controller enters a sticky lost state with all commands low. Only a synchronous reset leaves either of these states.

Top module: `maze_forager`

## Requirements
- R1: At most one of the seven command outputs is high in any cycle.
- R2: While `rst` is high at a rising edge, the controller returns to search with `carrying`, `lost`, the move budget and all commands cleared. After reset, a decision made from the inputs in a search cycle appears as a command in the following cycle.
- R3: In search, `batt_low` and `under_hole` both high select exit ahead of every other choice. From then on `cmd_exit` stays high on every cycle, whatever the inputs, until reset.
- R4: Pick-up is chosen only when `item_here` is high and the controller is not carrying. `carrying` becomes 1 in the cycle after the `cmd_pick` pulse. With an item already held, `item_here` has no effect.
- R5: When carrying and `under_hole` is high, the controller throws. Throw takes priority over light steering. `carrying` is 0 in the cycle after the `cmd_throw` pulse.
- R6: When `batt_low` or `carrying` is high and one light input is high, the controller steers by the light: left gives anticlockwise, forward gives a step, right gives clockwise, and behind gives a reversal. Steering takes priority over pick-up and wall following. In all other cases the light inputs have no effect.
- R7: Without steering, the controller follows the walls. A wall input high means a wall is present. The first open side in the order left, forward, right, behind is taken. With all four walls present, no command is issued.
- R8: A left or right turn is always followed by a forward step in the next cycle. A reversal is two consecutive clockwise turns, then a forward step.
- R9: The first cycle with `batt_low` high loads a budget of 50 moves. Each later cycle that carries a motion, pick or throw command uses one move. When the budget is spent, the next decision enters the lost state. Exactly 50 moves are issued in that case.
- R10: `lost` is sticky until reset. While `lost` is high, all commands are low, including exit under an opening.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single-phase clock |
| rst | input | 1 | Synchronous reset, active high |
| wall_l | input | 1 | Wall present on the left |
| wall_r | input | 1 | Wall present on the right |
| wall_f | input | 1 | Wall present ahead |
| wall_b | input | 1 | Wall present behind |
| lit_l | input | 1 | Opening lies to the left (one-hot light group) |
| lit_r | input | 1 | Opening lies to the right |
| lit_f | input | 1 | Opening lies ahead |
| lit_b | input | 1 | Opening lies behind |
| batt_low | input | 1 | Low-battery warning |
| item_here | input | 1 | An item is in the current cell |
| under_hole | input | 1 | The robot is under an overhead opening |
| cmd_fwd | output | 1 | Step forward |
| cmd_back | output | 1 | Step backward (used only by the back-step reversal variant) |
| cmd_cw | output | 1 | Turn 90 degrees clockwise |
| cmd_ccw | output | 1 | Turn 90 degrees anticlockwise |
| cmd_pick | output | 1 | Pick up the item |
| cmd_throw | output | 1 | Throw the held item up through the opening |
| cmd_exit | output | 1 | Leave through the opening and shut down |
| carrying | output | 1 | An item is held |
| lost | output | 1 | Move budget exhausted away from an opening |

## Verification
On every cycle, the embedded properties check four things: that commands are mutually exclusive; that exit and lost each hold once entered; that lost silences all commands; and that the budget never rises while armed. They also check that pick-up occurs only empty-handed, that a throw clears the carried item, and that a turn never ends without a step or a move to lost. The bench scenarios are needed for the decisions themselves: the priority order between exit, throw, light steering, pick-up and wall following, and the exact count of 50 moves before lost. They also cover the sequencing of reversals and the point at which reset recovers from the terminal states.

// File: rtl/forager_pkg.sv
package forager_pkg;

  typedef enum logic [3:0] {
    ST_SEARCH,
    ST_STEP,
    ST_TURN_L,
    ST_TURN_R,
    ST_REV_A,
    ST_REV_B,
    ST_BACK,
    ST_PICK,
    ST_THROW,
    ST_EXIT,
    ST_LOST
  } fsm_state_t;

  localparam int CMD_W     = 7;
  localparam int CMD_FWD   = 0;
  localparam int CMD_BACK  = 1;
  localparam int CMD_CW    = 2;
  localparam int CMD_CCW   = 3;
  localparam int CMD_PICK  = 4;
  localparam int CMD_THROW = 5;
  localparam int CMD_EXIT  = 6;

  // Direction preference shared by light steering and wall following:
  // left, then forward, then right, then behind.
  function automatic fsm_state_t pick_dir(input logic go_l, input logic go_f,
                                          input logic go_r, input logic go_b,
                                          input fsm_state_t rev_st);
    if (go_l)      return ST_TURN_L;
    else if (go_f) return ST_STEP;
    else if (go_r) return ST_TURN_R;
    else if (go_b) return rev_st;
    else           return ST_SEARCH;
  endfunction

  // States whose command spends one move of the budget.
  function automatic logic costs_move(input fsm_state_t s);
    case (s)
      ST_STEP, ST_TURN_L, ST_TURN_R, ST_REV_A, ST_REV_B,
      ST_BACK, ST_PICK, ST_THROW: return 1'b1;
      default:                    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/forager_budget.sv
module forager_budget #(
  parameter int BUDGET = 50,
  localparam int LEFT_W = $clog2(BUDGET + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              batt_low,
  input  logic              move,
  output logic              armed,
  output logic [LEFT_W-1:0] left
);

  function automatic logic [LEFT_W-1:0] spend(input logic [LEFT_W-1:0] v);
    return (v == '0) ? '0 : v - LEFT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      left  <= '0;
    end else if (!armed) begin
      if (batt_low) begin
        armed <= 1'b1;
        left  <= LEFT_W'(BUDGET);
      end
    end else if (move) begin
      left <= spend(left);
    end
  end

  // R9
  budget_down_chk: assert property (@(posedge clk) disable iff (rst)
    armed |=> (armed && left <= $past(left)));

endmodule

// File: rtl/forager_ctrl.sv
module forager_ctrl
  import forager_pkg::*;
#(
  parameter int LEFT_W = 6,
  parameter bit BACKSTEP_REVERSE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wall_l,
  input  logic              wall_r,
  input  logic              wall_f,
  input  logic              wall_b,
  input  logic              lit_l,
  input  logic              lit_r,
  input  logic              lit_f,
  input  logic              lit_b,
  input  logic              batt_low,
  input  logic              item_here,
  input  logic              under_hole,
  input  logic              armed,
  input  logic [LEFT_W-1:0] left,
  output fsm_state_t        st,
  output logic              carrying
);

  fsm_state_t nxt;
  fsm_state_t rev_entry;

  // Named events for the checks below
  logic spent;      // budget exhausted
  logic last_move;  // the move now in progress is the final one
  logic steer;
  logic any_lit;

  assign any_lit   = lit_l | lit_r | lit_f | lit_b;
  assign steer     = (batt_low | carrying) & any_lit;
  assign spent     = armed && (left == '0);
  assign last_move = armed && (left <= LEFT_W'(1));

  generate
    if (BACKSTEP_REVERSE) begin : g_rev_back
      assign rev_entry = ST_BACK;
    end else begin : g_rev_turns
      assign rev_entry = ST_REV_A;
    end
  endgenerate

  always_comb begin
    nxt = st;
    case (st)
      ST_SEARCH: begin
        if (batt_low && under_hole)      nxt = ST_EXIT;
        else if (spent)                  nxt = ST_LOST;
        else if (carrying && under_hole) nxt = ST_THROW;
        else if (steer)                  nxt = pick_dir(lit_l, lit_f, lit_r, lit_b, rev_entry);
        else if (!carrying && item_here) nxt = ST_PICK;
        else                             nxt = pick_dir(!wall_l, !wall_f, !wall_r, !wall_b, rev_entry);
      end
      ST_TURN_L, ST_TURN_R, ST_REV_B: nxt = last_move ? ST_LOST : ST_STEP;
      ST_REV_A:                       nxt = last_move ? ST_LOST : ST_REV_B;
      ST_STEP, ST_BACK,
      ST_PICK, ST_THROW:              nxt = ST_SEARCH;
      ST_EXIT:                        nxt = ST_EXIT;
      ST_LOST:                        nxt = ST_LOST;
      default:                        nxt = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_SEARCH;
      carrying <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_PICK)       carrying <= 1'b1;
      else if (st == ST_THROW) carrying <= 1'b0;
    end
  end

  // R4
  pick_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PICK) |-> (!carrying ##1 carrying));

  // R5
  throw_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_THROW) |=> !carrying);

  // R8
  turn_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TURN_L || st == ST_TURN_R) |=> (st == ST_STEP || st == ST_LOST));

endmodule

// File: rtl/forager_cmd_decode.sv
module forager_cmd_decode
  import forager_pkg::*;
(
  input  fsm_state_t       st,
  output logic [CMD_W-1:0] cmd,
  output logic             move,
  output logic             lost
);

  always_comb begin
    cmd = '0;
    case (st)
      ST_STEP:                     cmd[CMD_FWD]   = 1'b1;
      ST_BACK:                     cmd[CMD_BACK]  = 1'b1;
      ST_TURN_R, ST_REV_A, ST_REV_B: cmd[CMD_CW]  = 1'b1;
      ST_TURN_L:                   cmd[CMD_CCW]   = 1'b1;
      ST_PICK:                     cmd[CMD_PICK]  = 1'b1;
      ST_THROW:                    cmd[CMD_THROW] = 1'b1;
      ST_EXIT:                     cmd[CMD_EXIT]  = 1'b1;
      default:                     cmd = '0;
    endcase
  end

  assign move = costs_move(st);
  assign lost = (st == ST_LOST);

endmodule

// File: rtl/maze_forager.sv
module maze_forager
  import forager_pkg::*;
#(
  parameter int BUDGET = 50,
  parameter bit BACKSTEP_REVERSE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wall_l,
  input  logic wall_r,
  input  logic wall_f,
  input  logic wall_b,
  input  logic lit_l,
  input  logic lit_r,
  input  logic lit_f,
  input  logic lit_b,
  input  logic batt_low,
  input  logic item_here,
  input  logic under_hole,
  output logic cmd_fwd,
  output logic cmd_back,
  output logic cmd_cw,
  output logic cmd_ccw,
  output logic cmd_pick,
  output logic cmd_throw,
  output logic cmd_exit,
  output logic carrying,
  output logic lost
);

  localparam int LEFT_W = $clog2(BUDGET + 1);

  fsm_state_t        st;
  logic [CMD_W-1:0]  cmd;
  logic              move;
  logic              armed;
  logic [LEFT_W-1:0] left;

  forager_budget #(.BUDGET(BUDGET)) budget_i (
    .clk(clk), .rst(rst), .batt_low(batt_low), .move(move),
    .armed(armed), .left(left)
  );

  forager_ctrl #(.LEFT_W(LEFT_W), .BACKSTEP_REVERSE(BACKSTEP_REVERSE)) ctrl_i (
    .clk(clk), .rst(rst),
    .wall_l(wall_l), .wall_r(wall_r), .wall_f(wall_f), .wall_b(wall_b),
    .lit_l(lit_l), .lit_r(lit_r), .lit_f(lit_f), .lit_b(lit_b),
    .batt_low(batt_low), .item_here(item_here), .under_hole(under_hole),
    .armed(armed), .left(left), .st(st), .carrying(carrying)
  );

  forager_cmd_decode decode_i (
    .st(st), .cmd(cmd), .move(move), .lost(lost)
  );

  assign cmd_fwd   = cmd[CMD_FWD];
  assign cmd_back  = cmd[CMD_BACK];
  assign cmd_cw    = cmd[CMD_CW];
  assign cmd_ccw   = cmd[CMD_CCW];
  assign cmd_pick  = cmd[CMD_PICK];
  assign cmd_throw = cmd[CMD_THROW];
  assign cmd_exit  = cmd[CMD_EXIT];

  // R1
  one_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_fwd, cmd_back, cmd_cw, cmd_ccw, cmd_pick, cmd_throw, cmd_exit}));

  // R3
  exit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_exit |=> cmd_exit);

  // R10
  lost_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    lost |-> ({cmd_fwd, cmd_back, cmd_cw, cmd_ccw, cmd_pick, cmd_throw, cmd_exit} == '0));

  // R10
  lost_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lost |=> lost);

endmodule

// File: tb/maze_forager_tb_top.sv
module maze_forager_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wall_l = 0, wall_r = 0, wall_f = 0, wall_b = 0;
  logic lit_l = 0, lit_r = 0, lit_f = 0, lit_b = 0;
  logic batt_low = 0, item_here = 0, under_hole = 0;
  logic cmd_fwd, cmd_back, cmd_cw, cmd_ccw, cmd_pick, cmd_throw, cmd_exit;
  logic carrying, lost;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  maze_forager dut_i (
    .clk(clk), .rst(rst),
    .wall_l(wall_l), .wall_r(wall_r), .wall_f(wall_f), .wall_b(wall_b),
    .lit_l(lit_l), .lit_r(lit_r), .lit_f(lit_f), .lit_b(lit_b),
    .batt_low(batt_low), .item_here(item_here), .under_hole(under_hole),
    .cmd_fwd(cmd_fwd), .cmd_back(cmd_back), .cmd_cw(cmd_cw), .cmd_ccw(cmd_ccw),
    .cmd_pick(cmd_pick), .cmd_throw(cmd_throw), .cmd_exit(cmd_exit),
    .carrying(carrying), .lost(lost)
  );

  // Command vector order: {exit, throw, pick, ccw, cw, back, fwd}
  localparam logic [6:0] C_NONE  = 7'b0000000;
  localparam logic [6:0] C_FWD   = 7'b0000001;
  localparam logic [6:0] C_CW    = 7'b0000100;
  localparam logic [6:0] C_CCW   = 7'b0001000;
  localparam logic [6:0] C_PICK  = 7'b0010000;
  localparam logic [6:0] C_THROW = 7'b0100000;
  localparam logic [6:0] C_EXIT  = 7'b1000000;

  // Vector: walls{l,r,f,b}, lights{l,r,f,b}, flags{batt,item,hole,carry}, expected command
  localparam int NV = 15;
  localparam logic [18:0] VECS [NV] = '{
    {4'b1101, 4'b0000, 4'b0000, C_FWD},   // R7 forward only open
    {4'b0111, 4'b0000, 4'b0000, C_CCW},   // R7 left open
    {4'b1011, 4'b0000, 4'b0000, C_CW},    // R7 right open
    {4'b1110, 4'b0000, 4'b0000, C_CW},    // R7 behind open -> reverse
    {4'b1111, 4'b0000, 4'b0000, C_NONE},  // R7 boxed in
    {4'b0000, 4'b0000, 4'b0100, C_PICK},  // R4 pick when empty
    {4'b1101, 4'b0000, 4'b0101, C_FWD},   // R4 item ignored when carrying
    {4'b1111, 4'b0000, 4'b0011, C_THROW}, // R5 throw
    {4'b0000, 4'b0000, 4'b1111, C_EXIT},  // R3 exit beats all
    {4'b0000, 4'b0100, 4'b0001, C_CW},    // R6 carry steer right
    {4'b0000, 4'b0001, 4'b1000, C_CW},    // R6 low-battery steer behind
    {4'b0000, 4'b0100, 4'b0000, C_CCW},   // R6 light ignored when idle
    {4'b1111, 4'b1000, 4'b0001, C_CCW},   // R6 carry steer left
    {4'b1101, 4'b0000, 4'b0010, C_FWD},   // R5 opening without item ignored
    {4'b0000, 4'b0010, 4'b1100, C_FWD}    // R6 steering beats pick-up
  };

  function automatic logic [6:0] cmds();
    return {cmd_exit, cmd_throw, cmd_pick, cmd_ccw, cmd_cw, cmd_back, cmd_fwd};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [3:0] w, input logic [3:0] l,
                       input logic b, input logic it, input logic h);
    {wall_l, wall_r, wall_f, wall_b} = w;
    {lit_l, lit_r, lit_f, lit_b} = l;
    batt_low = b; item_here = it; under_hole = h;
  endtask

  task automatic do_reset();
    drive(4'b1111, 4'b0000, 0, 0, 0);
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  // Reaches the search state with an item held
  task automatic load_item();
    drive(4'b1111, 4'b0000, 0, 1, 0);
    tick();                         // pick pulse
    drive(4'b1111, 4'b0000, 0, 0, 0);
    tick();                         // back in search, carrying
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int fwd_count;
    @(negedge clk);
    do_reset();

    // R2 reset state
    chk("R2 reset outputs", {1'b0, cmds()}, 8'h00);
    chk("R2 reset flags", {6'b0, carrying, lost}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      if (VECS[i][7]) load_item();
      drive(VECS[i][18:15], VECS[i][14:11], VECS[i][10], VECS[i][9], VECS[i][8]);
      tick();
      chk($sformatf("R1/R6/R7 vector %0d", i), {1'b0, cmds()}, {1'b0, VECS[i][6:0]});
    end

    // R4 carrying set after pick, R5 cleared after throw
    do_reset();
    drive(4'b1111, 4'b0000, 0, 1, 0);
    tick();
    chk("R4 pick pulse", {1'b0, cmds()}, {1'b0, C_PICK});
    drive(4'b1111, 4'b0000, 0, 0, 1);
    tick();
    chk("R4 carrying set", {7'b0, carrying}, 8'h01);
    tick();
    chk("R5 throw pulse", {1'b0, cmds()}, {1'b0, C_THROW});
    drive(4'b1111, 4'b0000, 0, 0, 0);
    tick();
    chk("R5 carrying cleared", {7'b0, carrying}, 8'h00);

    // R8 turn then step
    do_reset();
    drive(4'b0111, 4'b0000, 0, 0, 0);
    tick();
    chk("R8 turn left", {1'b0, cmds()}, {1'b0, C_CCW});
    drive(4'b1111, 4'b0000, 0, 0, 0);
    tick();
    chk("R8 step after turn", {1'b0, cmds()}, {1'b0, C_FWD});

    // R8 reversal: cw, cw, step
    do_reset();
    drive(4'b1110, 4'b0000, 0, 0, 0);
    tick();
    chk("R8 reverse first", {1'b0, cmds()}, {1'b0, C_CW});
    drive(4'b1111, 4'b0000, 0, 0, 0);
    tick();
    chk("R8 reverse second", {1'b0, cmds()}, {1'b0, C_CW});
    tick();
    chk("R8 reverse step", {1'b0, cmds()}, {1'b0, C_FWD});
    tick();
    chk("R8 back to search", {1'b0, cmds()}, {1'b0, C_NONE});

    // R3 exit is terminal until reset
    do_reset();
    drive(4'b0000, 4'b0000, 1, 0, 1);
    tick();
    drive(4'b0000, 4'b0010, 0, 1, 0);
    for (int k = 0; k < 5; k++) tick();
    chk("R3 exit held", {1'b0, cmds()}, {1'b0, C_EXIT});
    do_reset();
    chk("R2 reset leaves exit", {1'b0, cmds()}, {1'b0, C_NONE});

    // R9 budget of 50 moves, R10 lost sticky and silent
    do_reset();
    drive(4'b1111, 4'b0010, 1, 0, 0);
    fwd_count = 0;
    for (int k = 0; k < 130; k++) begin
      tick();
      if (cmd_fwd) fwd_count++;
    end
    chk("R9 moves before lost", 8'(fwd_count), 8'd50);
    chk("R9 lost raised", {7'b0, lost}, 8'h01);
    drive(4'b0000, 4'b0000, 1, 0, 1);
    tick();
    tick();
    chk("R10 lost blocks exit", {1'b0, cmds()}, {1'b0, C_NONE});
    chk("R10 lost sticky", {7'b0, lost}, 8'h01);
    do_reset();
    chk("R2 reset clears lost", {7'b0, lost}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule